// File: doc/BRIEF.md
# Converter serial output sequencer

This block is the digital side of a sampling converter. It watches two active-low request lines and starts a conversion when their OR goes low. At that moment it captures the parallel sample code and drops `tracking` for a fixed number of system clocks. While that conversion runs, it sends out the code captured by the *previous* conversion on a serial line, most significant bit first.

The serial word can be timed in one of two ways. In internal mode the block makes its own shift clock: exactly `DW` pulses, placed inside the conversion window. The clock then stays low until the next conversion. In external mode the block makes no clock. It steps one bit for each rising edge seen on an external shift clock, whether or not a conversion is running. After reset no earlier code exists, so the first word is a fixed fill pattern, and a flag marks it.

Top module: `adc_serial_seq`

## Requirements
- R1: A conversion starts when `conv_req_n | dev_sel_n` goes from 1 to 0, in whichever order the two lines fall. `tracking` goes low at the third rising clock edge after that fall. One line low on its own starts nothing.
- R2: `tracking` is 1 after reset. It stays low for exactly `CONV_CYCLES` clock cycles per conversion and then returns to 1.
- R3: `sample_code` is captured at the start edge. Changes to it later in the conversion do not affect the word sent out during the next conversion.
- R4: With `use_ext_clk` = 0, `shift_clk_out` gives exactly `DW` pulses per conversion. Each pulse is high for `HALF` cycles and low for `HALF` cycles, and all pulses end before `tracking` rises.
- R5: `shift_clk_out` is 0 whenever `tracking` is 1, and after the last pulse of a conversion.
- R6: `ser_out` carries the code captured by the previous conversion, MSB first. Each bit is valid and stable for as long as `shift_clk_out` is high.
- R7: With `use_ext_clk` = 1, `shift_clk_out` stays 0. Each rising edge of `ext_shift_clk` moves `ser_out` on by one bit, up to `DW` steps per conversion, and the line then reads 0.
- R8: After reset, `placeholder_out` is 1 and `ser_out` is bit `DW-1` of `FILL`. The first conversion after reset sends `FILL` with `placeholder_out` = 1. Every later conversion sends real data with `placeholder_out` = 0.
- R9: A trigger that arrives while `tracking` is 0 is ignored. The conversion length, the pulse train and the captured code do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req_n | input | 1 | Conversion request, active low |
| dev_sel_n | input | 1 | Device select, active low; ORed with the request |
| use_ext_clk | input | 1 | 0 = generate shift clock, 1 = follow `ext_shift_clk` |
| sample_code | input | DW | Parallel sample code, captured at conversion start |
| ext_shift_clk | input | 1 | External shift clock, synchronised inside the block |
| tracking | output | 1 | 1 while tracking, 0 while a conversion runs |
| shift_clk_out | output | 1 | Internally generated shift clock |
| ser_out | output | 1 | Serial data, MSB first |
| placeholder_out | output | 1 | 1 while the serial word is the fill pattern |

## Verification
The checker tests four things on every cycle:
- each low stretch of `tracking` lasts exactly `CONV_CYCLES` cycles;
- the shift clock is quiet while tracking and while in external mode;
- no conversion sees more than `DW` clock rises;
- `ser_out` never moves while the shift clock is high.

Only the bench scenarios can show the rest: the word sent really is the previous conversion's code, in MSB-first order. They also show that a retrigger during a conversion leaves the captured code alone, that the fill pattern and flag return after a reset, and that external edges step the word one bit at a time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {
    CLK_INT = 1'b0,
    CLK_EXT = 1'b1
  } clk_src_e;

  // Cycles taken by a full internal pulse train.
  function automatic int pulse_span(input int bits, input int half);
    return bits * 2 * half;
  endfunction
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int STAGES      = 2,
  parameter bit RST_VAL     = 1'b0,
  parameter bit DETECT_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{RST_VAL}};
      last <= RST_VAL;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      last <= pipe[STAGES-1];
    end
  end

  generate
    if (DETECT_RISE) begin : g_rise
      assign hit = pipe[STAGES-1] & ~last;
    end else begin : g_fall
      assign hit = ~pipe[STAGES-1] & last;
    end
  endgenerate
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
  parameter int CONV_CYCLES = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_fall,
  output logic tracking,
  output logic start
);
  localparam int            CW   = $clog2(CONV_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt;

  // A trigger only counts while tracking; a retrigger is dropped here.
  assign start = trig_fall & tracking;

  always_ff @(posedge clk) begin
    if (rst) begin
      tracking <= 1'b1;
      cnt      <= '0;
    end else if (start) begin
      tracking <= 1'b0;
      cnt      <= '0;
    end else if (!tracking) begin
      if (cnt == LAST) tracking <= 1'b1;
      else             cnt      <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/seq_pulse_gen.sv
module seq_pulse_gen #(
  parameter int DW   = 16,
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic sclk,
  output logic tick
);
  localparam int               PH_W    = $clog2(2 * HALF);
  localparam int               PC_W    = $clog2(DW + 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(2 * HALF - 1);
  localparam logic [PH_W-1:0]  PH_HI   = PH_W'(HALF);
  localparam logic [PC_W-1:0]  PC_MAX  = PC_W'(DW);

  logic [PH_W-1:0] ph;
  logic [PC_W-1:0] pc;
  logic            active;

  assign active = run && (pc != PC_MAX);
  // The shift lands at the end of a low phase, one cycle before the next rise.
  assign tick   = active && (ph == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      ph   <= '0;
      pc   <= '0;
      sclk <= 1'b0;
    end else if (active) begin
      sclk <= (ph < PH_HI);
      if (ph == PH_LAST) begin
        ph <= '0;
        pc <= pc + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end else begin
      sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_shifter.sv
module seq_shifter #(
  parameter int            DW   = 16,
  parameter logic [DW-1:0] FILL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] sample,
  input  logic          tick,
  output logic          ser,
  output logic          stale
);
  localparam int            PC_W   = $clog2(DW + 1);
  localparam logic [PC_W-1:0] PC_MAX = PC_W'(DW);

  logic [DW-1:0]   held;
  logic [DW-1:0]   sreg;
  logic            have_prev;
  logic [PC_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= '0;
      sreg      <= FILL;
      have_prev <= 1'b0;
      cnt       <= PC_MAX;
      stale     <= 1'b1;
    end else if (start) begin
      held      <= sample;
      sreg      <= have_prev ? held : FILL;
      stale     <= !have_prev;
      have_prev <= 1'b1;
      cnt       <= '0;
    end else if (tick && (cnt != PC_MAX)) begin
      sreg <= {sreg[DW-2:0], 1'b0};
      cnt  <= cnt + 1'b1;
    end
  end

  assign ser = sreg[DW-1];
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter int            DW          = 16,
  parameter int            CONV_CYCLES = 80,
  parameter int            HALF        = 2,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-1:0] FILL        = 16'hA5C3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          conv_req_n,
  input  logic          dev_sel_n,
  input  logic          use_ext_clk,
  input  logic [DW-1:0] sample_code,
  input  logic          ext_shift_clk,
  output logic          tracking,
  output logic          shift_clk_out,
  output logic          ser_out,
  output logic          placeholder_out
);
  generate
    if (CONV_CYCLES <= pulse_span(DW, HALF)) begin : g_bad_cfg
      $error("conversion window too short for the pulse train");
    end
  endgenerate

  clk_src_e src;
  logic     trig_fall, ext_rise, start, run, int_tick, tick;

  assign src = clk_src_e'(use_ext_clk);

  seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .DETECT_RISE(1'b0)) u_trig_sync (
    .clk(clk), .rst(rst), .din(conv_req_n | dev_sel_n), .hit(trig_fall)
  );

  seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .DETECT_RISE(1'b1)) u_ext_sync (
    .clk(clk), .rst(rst), .din(ext_shift_clk), .hit(ext_rise)
  );

  seq_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .trig_fall(trig_fall), .tracking(tracking), .start(start)
  );

  assign run = !tracking && (src == CLK_INT);

  seq_pulse_gen #(.DW(DW), .HALF(HALF)) u_pulse (
    .clk(clk), .rst(rst), .start(start), .run(run),
    .sclk(shift_clk_out), .tick(int_tick)
  );

  assign tick = (src == CLK_EXT) ? ext_rise : int_tick;

  seq_shifter #(.DW(DW), .FILL(FILL)) u_shift (
    .clk(clk), .rst(rst), .start(start), .sample(sample_code), .tick(tick),
    .ser(ser_out), .stale(placeholder_out)
  );
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk #(
  parameter int DW          = 16,
  parameter int CONV_CYCLES = 80
) (
  input logic clk,
  input logic rst,
  input logic tracking,
  input logic shift_clk_out,
  input logic ser_out,
  input logic use_ext_clk
);
  localparam int            BW     = $clog2(CONV_CYCLES + 2);
  localparam int            PW     = $clog2(DW + 2);
  localparam logic [BW-1:0] B_MAX  = {BW{1'b1}};
  localparam logic [PW-1:0] P_MAX  = {PW{1'b1}};

  logic [BW-1:0] busy_cnt;
  logic [PW-1:0] rise_cnt;
  logic          clk_q, trk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      rise_cnt <= '0;
      clk_q    <= 1'b0;
      trk_q    <= 1'b1;
    end else begin
      clk_q <= shift_clk_out;
      trk_q <= tracking;
      if (tracking)              busy_cnt <= '0;
      else if (busy_cnt != B_MAX) busy_cnt <= busy_cnt + 1'b1;
      if (!tracking && trk_q)    rise_cnt <= '0;
      else if (shift_clk_out && !clk_q && rise_cnt != P_MAX) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    (tracking && !trk_q) |-> (busy_cnt == BW'(CONV_CYCLES))); // R2
  AST_CLK_QUIET_TRACK: assert property (@(posedge clk) disable iff (rst)
    tracking |-> !shift_clk_out); // R5
  AST_CLK_QUIET_EXT: assert property (@(posedge clk) disable iff (rst)
    (use_ext_clk && $past(use_ext_clk)) |-> !shift_clk_out); // R7
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst)
    rise_cnt <= PW'(DW)); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    shift_clk_out |-> $stable(ser_out)); // R6
endmodule

bind adc_serial_seq adc_serial_seq_chk #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .tracking(tracking), .shift_clk_out(shift_clk_out),
  .ser_out(ser_out), .use_ext_clk(use_ext_clk)
);

// File: tb/adc_serial_seq_tb.sv
module adc_serial_seq_tb;
  localparam int            DW   = 16;
  localparam int            CONV = 80;
  localparam int            HALF = 2;
  localparam logic [DW-1:0] FILL = 16'hA5C3;

  // {external mode, trigger order, sample code}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 2'd0, 16'h1234},
    {1'b0, 2'd1, 16'hBEEF},
    {1'b1, 2'd2, 16'h8001},
    {1'b0, 2'd2, 16'h0F0F},
    {1'b1, 2'd0, 16'hFFFF},
    {1'b0, 2'd1, 16'h0000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic conv_req_n = 1'b1, dev_sel_n = 1'b1, use_ext_clk = 1'b0, ext_shift_clk = 1'b0;
  logic [DW-1:0] sample_code = '0;
  logic tracking, shift_clk_out, ser_out, placeholder_out;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  adc_serial_seq #(.DW(DW), .CONV_CYCLES(CONV), .HALF(HALF), .FILL(FILL)) u_dut (
    .clk(clk), .rst(rst), .conv_req_n(conv_req_n), .dev_sel_n(dev_sel_n),
    .use_ext_clk(use_ext_clk), .sample_code(sample_code), .ext_shift_clk(ext_shift_clk),
    .tracking(tracking), .shift_clk_out(shift_clk_out), .ser_out(ser_out),
    .placeholder_out(placeholder_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive the two request lines low in the given order and check R1 latency.
  task automatic fire(input logic [1:0] order, input logic [DW-1:0] code);
    @(negedge clk);
    sample_code = code;
    case (order)
      2'd0: begin conv_req_n = 1'b0; @(negedge clk); dev_sel_n = 1'b0; end
      2'd1: begin dev_sel_n = 1'b0; @(negedge clk); conv_req_n = 1'b0; end
      default: begin conv_req_n = 1'b0; dev_sel_n = 1'b0; end
    endcase
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(tracking == 1'b1, "R1 tracking before third edge", 32'(tracking), 1);
    @(negedge clk);
    chk(tracking == 1'b0, "R1 tracking low at third edge", 32'(tracking), 0);
    conv_req_n = 1'b1;
    dev_sel_n  = 1'b1;
  endtask

  task automatic run_int(input logic [1:0] order, input logic [DW-1:0] code,
                         input logic [DW-1:0] exp_word, input bit exp_stale,
                         input int retrig_at, input logic [DW-1:0] retrig_code);
    int busy = 1, pulses = 0, hi = 0, late = 0;
    logic prev = 1'b0;
    logic [DW-1:0] word = '0;
    use_ext_clk = 1'b0;
    fire(order, code);
    for (int i = 0; i < 4 * CONV; i++) begin
      if (retrig_at != 0 && busy == retrig_at) begin
        sample_code = retrig_code;
        conv_req_n  = 1'b0;
        dev_sel_n   = 1'b0;
      end
      if (retrig_at != 0 && busy == retrig_at + 6) begin
        conv_req_n = 1'b1;
        dev_sel_n  = 1'b1;
      end
      @(negedge clk);
      if (tracking) break;
      busy++;
      if (shift_clk_out) hi++;
      if (shift_clk_out && !prev) begin
        word = {word[DW-2:0], ser_out};
        pulses++;
      end
      prev = shift_clk_out;
    end
    chk(busy == CONV, "R2 conversion length", busy, CONV);
    chk(pulses == DW, "R4 pulse count", pulses, DW);
    chk(hi == DW * HALF, "R4 high cycles", hi, DW * HALF);
    chk(word == exp_word, "R6 R3 serial word", word, exp_word);
    chk(placeholder_out == exp_stale, "R8 placeholder flag", 32'(placeholder_out), 32'(exp_stale));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (shift_clk_out) late++;
    end
    chk(late == 0, "R5 clock low after train", late, 0);
  endtask

  task automatic run_ext(input logic [1:0] order, input logic [DW-1:0] code,
                         input logic [DW-1:0] exp_word, input bit exp_stale);
    int noisy = 0;
    logic [DW-1:0] word = '0;
    use_ext_clk = 1'b1;
    fire(order, code);
    for (int k = 0; k < DW; k++) begin
      word = {word[DW-2:0], ser_out};
      ext_shift_clk = 1'b1;
      repeat (4) begin @(negedge clk); if (shift_clk_out) noisy++; end
      ext_shift_clk = 1'b0;
      repeat (4) begin @(negedge clk); if (shift_clk_out) noisy++; end
    end
    chk(word == exp_word, "R7 R6 external word", word, exp_word);
    chk(noisy == 0, "R7 no internal clock", noisy, 0);
    chk(ser_out == 1'b0, "R7 line zero after word", 32'(ser_out), 0);
    chk(placeholder_out == exp_stale, "R8 placeholder flag", 32'(placeholder_out), 32'(exp_stale));
    for (int i = 0; i < 4 * CONV && !tracking; i++) @(negedge clk);
    use_ext_clk = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tracking == 1'b1, "R2 reset tracking", 32'(tracking), 1);
    chk(shift_clk_out == 1'b0, "R5 reset clock", 32'(shift_clk_out), 0);
    chk(placeholder_out == 1'b1, "R8 reset flag", 32'(placeholder_out), 1);
    chk(ser_out == FILL[DW-1], "R8 reset line", 32'(ser_out), 32'(FILL[DW-1]));

    for (int i = 0; i < 6; i++) begin
      logic [DW-1:0] exp_w;
      exp_w = (i == 0) ? FILL : VEC[i-1][DW-1:0];
      if (VEC[i][18]) run_ext(VEC[i][17:16], VEC[i][DW-1:0], exp_w, i == 0);
      else            run_int(VEC[i][17:16], VEC[i][DW-1:0], exp_w, i == 0, 0, '0);
    end

    // R1: a single low line starts nothing
    begin
      int lows = 0;
      @(negedge clk); conv_req_n = 1'b0;
      repeat (12) begin @(negedge clk); if (!tracking) lows++; end
      conv_req_n = 1'b1; @(negedge clk); dev_sel_n = 1'b0;
      repeat (12) begin @(negedge clk); if (!tracking) lows++; end
      dev_sel_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(lows == 0, "R1 single line ignored", lows, 0);
    end

    // R9, R3: retrigger with a new code during a conversion is ignored
    run_int(2'd2, 16'h5A5A, 16'h0000, 1'b0, 20, 16'h3C3C);
    run_int(2'd0, 16'h7777, 16'h5A5A, 1'b0, 0, '0);

    // R8: reset mid-conversion brings back the fill word and flag
    use_ext_clk = 1'b0;
    fire(2'd2, 16'h1111);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tracking == 1'b1, "R2 tracking after reset", 32'(tracking), 1);
    chk(placeholder_out == 1'b1, "R8 flag after reset", 32'(placeholder_out), 1);
    chk(ser_out == FILL[DW-1], "R8 line after reset", 32'(ser_out), 32'(FILL[DW-1]));
    run_int(2'd1, 16'h2222, FILL, 1'b1, 0, '0);
    run_int(2'd2, 16'h4444, 16'h2222, 1'b0, 0, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule